// File: doc/BRIEF.md
# Real-time clock multi-purpose open-drain pin driver

This block drives a single open-drain pin of a real-time clock. It is clocked by the 32.768 kHz timebase and runs a free-running divider that supplies slower square waves. Three control bits, loaded together by a write strobe, decide what the pin carries:
- an active-low alarm indication,
- a fixed 512 Hz calibration tone,
- a continuous square wave at one of four selectable frequencies.

The pin is modelled as a single drive-low enable. When the enable is 1 the line is pulled low. When it is 0 the line is released, and an external pull-up makes it read high. An alarm-pending flag is set by a match pulse from the alarm comparator and is cleared by a separate strobe.

Top module: `rtc_multipin_out`

## Requirements
- R1: While reset is asserted, and after it, the mode is alarm, no alarm is pending and the divider count is zero, so `pin_drive_low` is 0 (line released). Reset is synchronous and active low.
- R2: In alarm mode (`ctl_cal`=0, `ctl_alarm_sel`=1) `pin_drive_low` equals the alarm-pending flag. A pending alarm pulls the line low.
- R3: `alarm_match` high at an edge sets the pending flag from that edge on. The flag holds until an edge with `alarm_clr` high and `alarm_match` low, which clears it. When both are high at the same edge, the flag is set.
- R4: In calibration mode (`ctl_cal`=1) the pin carries 512 Hz whatever `ctl_freq` is. `pin_drive_low` is 1 exactly while bit 5 of the divider count is 0.
- R5: When `ctl_cal`=1 it takes priority over `ctl_alarm_sel`. With both set, the output is the calibration tone, not the alarm.
- R6: Square-wave mode is selected when `ctl_cal`=0 and `ctl_alarm_sel`=0. With `ctl_freq`=00 (1 Hz), `pin_drive_low` is 1 exactly while bit 14 of the count is 0, so the line changes every 16384 cycles.
- R7: In square-wave mode, `ctl_freq`=01 gives 512 Hz (low while count bit 5 is 0). `ctl_freq`=10 gives 4096 Hz (low while count bit 2 is 0).
- R8: In square-wave mode with `ctl_freq`=11 the pin follows the input clock: released while `clk` is high and pulled low while `clk` is low. This starts from the first falling edge after the write. During the high phase just after the write the line is held low.
- R9: The control bits are loaded only at an edge with `ctl_wr`=1 and take effect from that edge. Changes to the control inputs without the strobe have no effect. The divider count starts at zero after reset, increments by one at every edge (wrapping modulo 32768), and is never restarted by a mode or frequency change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Load strobe for the control bits |
| ctl_alarm_sel | input | 1 | 1 = alarm output, 0 = square wave (when not calibrating) |
| ctl_cal | input | 1 | 1 = calibration tone, highest priority |
| ctl_freq | input | 2 | Square-wave frequency: 00 1 Hz, 01 512 Hz, 10 4096 Hz, 11 full rate |
| alarm_match | input | 1 | Alarm comparator hit pulse |
| alarm_clr | input | 1 | Clear strobe for the pending alarm |
| pin_drive_low | output | 1 | 1 pulls the open-drain line low, 0 releases it |

## Verification
The hardest situation to reach is the 1 Hz selection. Its first change needs 16384 cycles of divider phase, and its phase must line up with a count that mode changes must not have disturbed. The stimulus table first runs the 512 Hz and 4096 Hz selections and the calibration tone, then switches to 1 Hz. It holds that selection for more than 32768 cycles, so the output is seen to change in both directions, at count positions predicted from a reference count the bench keeps from reset.

// File: rtl/rtc_pin_pkg.sv
// Package: shared types for the RTC multi-purpose pin driver.
// Assumes the block is clocked by the 32.768 kHz timebase.
package rtc_pin_pkg;

    // What the pin currently shows.
    typedef enum logic [1:0] {
        PIN_ALARM = 2'd0,
        PIN_CAL   = 2'd1,
        PIN_WAVE  = 2'd2
    } pin_mode_e;

    // Square-wave frequency codes.
    localparam logic [1:0] FQ_1HZ  = 2'b00;
    localparam logic [1:0] FQ_512  = 2'b01;
    localparam logic [1:0] FQ_4096 = 2'b10;
    localparam logic [1:0] FQ_FULL = 2'b11;

    // Index of each divider tap within the tap vector.
    localparam int TAP_IDX_MID  = 0;
    localparam int TAP_IDX_CAL  = 1;
    localparam int TAP_IDX_SLOW = 2;
    localparam int TAP_COUNT    = 3;

endpackage

// File: rtl/rtc_tap_divider.sv
// Module: free-running divider on the timebase clock.
// It counts up by one every cycle, wraps at 2**DIV_W and exports only the
// count bits picked by the tap parameters. Each tap bit is a square wave of
// period 2**(pos+1) cycles. Assumes every tap position is below DIV_W.
module rtc_tap_divider
    import rtc_pin_pkg::*;
#(
    parameter int DIV_W    = 15,
    parameter int TAP_MID  = 2,
    parameter int TAP_CAL  = 5,
    parameter int TAP_SLOW = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [TAP_COUNT-1:0] taps
);

    localparam int TOP_BIT = DIV_W - 1;
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [TOP_BIT:0] cnt_q;

    // Purpose: advance the count every cycle; only reset restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // Purpose: route the chosen count bits onto the tap vector.
    always_comb begin
        taps               = '0;
        taps[TAP_IDX_MID]  = cnt_q[TAP_MID];
        taps[TAP_IDX_CAL]  = cnt_q[TAP_CAL];
        taps[TAP_IDX_SLOW] = cnt_q[TAP_SLOW];
    end

endmodule

// File: rtl/rtc_pin_ctl.sv
// Module: control register for the pin mode and frequency.
// It loads all bits together on a write strobe and decodes the mode once, at
// load time. The calibration bit outranks the alarm/square-wave select bit.
// Assumes the strobe is synchronous to clk.
module rtc_pin_ctl
    import rtc_pin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       alarm_sel,
    input  logic       cal,
    input  logic [1:0] freq,
    output pin_mode_e  mode_q,
    output logic [1:0] freq_q
);

    pin_mode_e mode_d;

    // Purpose: decode the incoming bits into a mode, calibration first.
    always_comb begin
        if (cal) begin
            mode_d = PIN_CAL;
        end else if (alarm_sel) begin
            mode_d = PIN_ALARM;
        end else begin
            mode_d = PIN_WAVE;
        end
    end

    // Purpose: hold the mode and frequency; load only on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PIN_ALARM;
            freq_q <= FQ_1HZ;
        end else if (wr) begin
            mode_q <= mode_d;
            freq_q <= freq;
        end
    end

endmodule

// File: rtl/rtc_alarm_flag.sv
// Module: alarm pending flag.
// A match pulse sets the flag and it stays set until a clear strobe. If the
// set and the clear arrive in the same cycle, the set wins.
// Assumes both inputs are synchronous one-cycle strobes.
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_q
);

    // Purpose: set/hold/clear the pending state, with set taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_i) begin
            pend_q <= 1'b1;
        end else if (clr_i) begin
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_pin_select.sv
// Module: output selector for the open-drain pin.
// It picks between the alarm flag, the calibration tap and the four
// square-wave sources. The full-rate source is the clock itself, gated by an
// enable that changes on the falling edge, so it is stable while clk is
// high. The output is a drive-low enable: 1 pulls the line low.
module rtc_pin_select
    import rtc_pin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  pin_mode_e            mode,
    input  logic [1:0]           freq,
    input  logic                 pend,
    input  logic [TAP_COUNT-1:0] taps,
    output logic                 drive_low
);

    logic pass_en_q;
    logic full_sel;
    logic wave_level;

    assign full_sel = (mode == PIN_WAVE) && (freq == FQ_FULL);

    // Purpose: update the pass-through gate only while clk is low.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            pass_en_q <= 1'b0;
        end else begin
            pass_en_q <= full_sel;
        end
    end

    // Purpose: choose the line level from the square-wave frequency code.
    always_comb begin
        case (freq)
            FQ_1HZ:  wave_level = taps[TAP_IDX_SLOW];
            FQ_512:  wave_level = taps[TAP_IDX_CAL];
            FQ_4096: wave_level = taps[TAP_IDX_MID];
            default: wave_level = clk & pass_en_q;
        endcase
    end

    // Purpose: map the active source onto the open-drain enable.
    always_comb begin
        case (mode)
            PIN_ALARM: drive_low = pend;
            PIN_CAL:   drive_low = ~taps[TAP_IDX_CAL];
            default:   drive_low = ~wave_level;
        endcase
    end

endmodule

// File: rtl/rtc_multipin_out.sv
// Module: top of the RTC multi-purpose open-drain pin driver.
// It ties together the divider, the control register, the alarm flag and the
// output selector. Clocked by the 32.768 kHz timebase; synchronous
// active-low reset.
module rtc_multipin_out
    import rtc_pin_pkg::*;
#(
    parameter int DIV_W    = 15,
    parameter int TAP_MID  = 2,
    parameter int TAP_CAL  = 5,
    parameter int TAP_SLOW = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       ctl_alarm_sel,
    input  logic       ctl_cal,
    input  logic [1:0] ctl_freq,
    input  logic       alarm_match,
    input  logic       alarm_clr,
    output logic       pin_drive_low
);

    logic [TAP_COUNT-1:0] div_taps;
    pin_mode_e            mode_q;
    logic [1:0]           freq_q;
    logic                 alarm_pend;

    rtc_tap_divider #(
        .DIV_W   (DIV_W),
        .TAP_MID (TAP_MID),
        .TAP_CAL (TAP_CAL),
        .TAP_SLOW(TAP_SLOW)
    ) div_i (
        .clk  (clk),
        .rst_n(rst_n),
        .taps (div_taps)
    );

    rtc_pin_ctl ctl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .alarm_sel(ctl_alarm_sel),
        .cal      (ctl_cal),
        .freq     (ctl_freq),
        .mode_q   (mode_q),
        .freq_q   (freq_q)
    );

    rtc_alarm_flag flag_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (alarm_match),
        .clr_i (alarm_clr),
        .pend_q(alarm_pend)
    );

    rtc_pin_select sel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .freq     (freq_q),
        .pend     (alarm_pend),
        .taps     (div_taps),
        .drive_low(pin_drive_low)
    );

endmodule

// File: rtl/rtc_multipin_out_chk.sv
// Checker: properties of the RTC pin driver, attached to the top by bind.
module rtc_multipin_out_chk
    import rtc_pin_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctl_wr,
    input logic                 alarm_match,
    input logic                 alarm_clr,
    input logic                 pin_drive_low,
    input logic [1:0]           mode,
    input logic                 pend,
    input logic [TAP_COUNT-1:0] taps
);

    // R3: a match pulse sets the flag, even together with a clear.
    assert_pend_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_match |=> pend);

    // R3: without a clear, a pending alarm stays pending.
    assert_pend_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !alarm_clr) |=> pend);

    // R3: a clear without a match empties the flag.
    assert_pend_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_clr && !alarm_match) |=> !pend);

    // R2: in alarm mode the pin shows the pending flag.
    assert_alarm_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PIN_ALARM) |-> (pin_drive_low == pend));

    // R4: in calibration mode the pin follows the 512 Hz tap.
    assert_cal_tone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PIN_CAL) |-> (pin_drive_low == !taps[TAP_IDX_CAL]));

    // R9: the mode does not move without a write strobe.
    assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(mode));

endmodule

bind rtc_multipin_out rtc_multipin_out_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr       (ctl_wr),
    .alarm_match  (alarm_match),
    .alarm_clr    (alarm_clr),
    .pin_drive_low(pin_drive_low),
    .mode         (mode_q),
    .pend         (alarm_pend),
    .taps         (div_taps)
);

// File: tb/rtc_multipin_out_tb_top.sv
// Bench for the RTC multi-purpose pin driver. The 50 MHz clock stands in for
// the timebase. Inputs change at 5 ns after an edge (clk high phase) or at
// 15 ns (clk low phase), never at an edge.
module rtc_multipin_out_tb_top;

    typedef struct packed {
        logic        asel;
        logic        cal;
        logic [1:0]  fq;
        int unsigned ncyc;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 2'b11, 200},    // calibration, freq ignored
        '{1'b1, 1'b1, 2'b00, 200},    // calibration beats alarm select
        '{1'b0, 1'b0, 2'b01, 200},    // 512 Hz
        '{1'b0, 1'b0, 2'b10, 100},    // 4096 Hz
        '{1'b0, 1'b0, 2'b11, 60},     // full rate
        '{1'b0, 1'b0, 2'b00, 33000},  // 1 Hz
        '{1'b1, 1'b0, 2'b10, 30}      // back to alarm, nothing pending
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       ctl_alarm_sel = 1'b0;
    logic       ctl_cal = 1'b0;
    logic [1:0] ctl_freq = 2'b00;
    logic       alarm_match = 1'b0;
    logic       alarm_clr = 1'b0;
    logic       pin_drive_low;

    int unsigned bcnt = 0;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;

    always #10ns clk = ~clk;

    // Reference count: zero under reset, then one per edge.
    always @(posedge clk) begin
        if (!rst_n) bcnt <= 0;
        else        bcnt <= bcnt + 1;
    end

    rtc_multipin_out dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr),
        .ctl_alarm_sel(ctl_alarm_sel),
        .ctl_cal      (ctl_cal),
        .ctl_freq     (ctl_freq),
        .alarm_match  (alarm_match),
        .alarm_clr    (alarm_clr),
        .pin_drive_low(pin_drive_low)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s pin_drive_low actual=%0b expected=%0b count=%0d t=%0t",
                     req, act, exp, bcnt, $time);
        end
    endtask

    // Move to 5 ns after the next rising edge.
    task automatic adv();
        @(posedge clk);
        #5ns;
    endtask

    task automatic write_ctl(input logic a, input logic c, input logic [1:0] f);
        ctl_alarm_sel = a;
        ctl_cal       = c;
        ctl_freq      = f;
        ctl_wr        = 1'b1;
        adv();
        ctl_wr        = 1'b0;
    endtask

    function automatic logic exp_low(input logic a, input logic c, input logic [1:0] f,
                                     input logic pend, input int unsigned cnt,
                                     input logic clk_hi);
        if (c)      return !cnt[5];
        else if (a) return pend;
        case (f)
            2'b00:   return !cnt[14];
            2'b01:   return !cnt[5];
            2'b10:   return !cnt[2];
            default: return !clk_hi;
        endcase
    endfunction

    function automatic string tag_of(input logic a, input logic c, input logic [1:0] f);
        if (c && a)      return "R5";
        if (c)           return "R4";
        if (a)           return "R2";
        if (f == 2'b00)  return "R6/R9";
        if (f == 2'b11)  return "R8";
        return "R7/R9";
    endfunction

    initial begin
        // R1: reset state, during and after reset.
        adv();
        chk("R1 in reset", pin_drive_low, 1'b0);
        adv();
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            adv();
            chk("R1 after reset", pin_drive_low, 1'b0);
        end

        // Table walk: each vector loads the control bits and is checked per cycle.
        for (int i = 0; i < NV; i++) begin
            write_ctl(VECS[i].asel, VECS[i].cal, VECS[i].fq);
            for (int k = 0; k < int'(VECS[i].ncyc); k++) begin
                if (k > 0) adv();
                if (!(k == 0 && !VECS[i].cal && !VECS[i].asel && VECS[i].fq == 2'b11))
                    chk(tag_of(VECS[i].asel, VECS[i].cal, VECS[i].fq), pin_drive_low,
                        exp_low(VECS[i].asel, VECS[i].cal, VECS[i].fq, 1'b0, bcnt, 1'b1));
                else
                    chk("R8 first high phase", pin_drive_low, 1'b1);
                if (VECS[i].ncyc < 1000) begin
                    #10ns;
                    chk(tag_of(VECS[i].asel, VECS[i].cal, VECS[i].fq), pin_drive_low,
                        exp_low(VECS[i].asel, VECS[i].cal, VECS[i].fq, 1'b0, bcnt, 1'b0));
                end
            end
        end

        // R9: control inputs change without the strobe; the line stays released.
        ctl_cal = 1'b1; ctl_freq = 2'b01; ctl_alarm_sel = 1'b0;
        for (int k = 0; k < 70; k++) begin
            adv();
            chk("R9 no strobe", pin_drive_low, 1'b0);
        end
        write_ctl(1'b1, 1'b0, 2'b00);

        // R2/R3: set, hold, clear.
        alarm_match = 1'b1;
        adv();
        alarm_match = 1'b0;
        chk("R2 alarm pulls low", pin_drive_low, 1'b1);
        for (int k = 0; k < 10; k++) begin
            adv();
            chk("R3 hold", pin_drive_low, 1'b1);
        end
        alarm_clr = 1'b1;
        adv();
        alarm_clr = 1'b0;
        chk("R3 clear", pin_drive_low, 1'b0);

        // R3: set and clear together, the set wins.
        alarm_match = 1'b1; alarm_clr = 1'b1;
        adv();
        alarm_match = 1'b0; alarm_clr = 1'b0;
        chk("R3 set wins", pin_drive_low, 1'b1);
        alarm_clr = 1'b1;
        adv();
        alarm_clr = 1'b0;
        chk("R3 clear again", pin_drive_low, 1'b0);

        // R4/R2: alarm arrives during calibration, shows once back in alarm mode.
        write_ctl(1'b1, 1'b1, 2'b10);
        alarm_match = 1'b1;
        adv();
        alarm_match = 1'b0;
        for (int k = 0; k < 70; k++) begin
            chk("R4 tone while pending", pin_drive_low, !bcnt[5]);
            adv();
        end
        write_ctl(1'b1, 1'b0, 2'b10);
        chk("R2 pending kept across modes", pin_drive_low, 1'b1);

        // R1: reset mid-run releases the line and restores alarm mode.
        write_ctl(1'b0, 1'b1, 2'b00);
        rst_n = 1'b0;
        adv();
        chk("R1 reset mid-run", pin_drive_low, 1'b0);
        rst_n = 1'b1;
        for (int k = 0; k < 40; k++) begin
            adv();
            chk("R1 alarm mode after reset", pin_drive_low, 1'b0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #4ms;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule